// File: doc/BRIEF.md
# Dual-Precision Integer Execute Unit

This block sits in the execute stage of an integer pipeline. It holds two copies of the same ALU. One copy is exact. The other is a shadow copy that models a unit running at a reduced supply, so its results may be slightly wrong. Every operation arrives with a one-bit precision tag. That tag picks which copy runs the operation, and only that copy's power-gate enable is raised for the cycle. Both copies feed one registered result port. The block takes one operation per cycle, and changing from one copy to the other costs no cycle, even when the tag alternates on every operation.

The shadow copy computes the exact value and then XORs its low four bits with the low bits of a 16-bit LFSR. The LFSR advances once for each accepted approximate operation. Its value can be loaded, so the error pattern is repeatable. Precise operations raise an exception on signed overflow or on an undefined opcode. Approximate operations never raise one, and the only thing they change is their own result (plus the noise generator they consume).

A small state machine records which copy produced the value now on the result port. Its states are ST_IDLE (no result this cycle), ST_PREC (result from the exact copy) and ST_APPX (result from the shadow copy). Every cycle it moves to ST_IDLE when no operation is offered. Otherwise it moves to ST_APPX or ST_PREC according to the tag. Any state can reach any other state in a single cycle.

Top module: `dual_precision_alu`

## Requirements
- R1: Opcode encodings: 0 add, 1 subtract, 2 AND, 3 OR, 4 XNOR, 5 logical shift right of A by B[3:0], 6 set-if-A≤B unsigned (result 1 or 0), 7 undefined (result 0). When a precise operation is accepted, the bit-exact result appears on `out_result` on the next cycle, with `out_valid` high.
- R2: When `in_valid` is high, exactly one gate enable is high in that same cycle: `pwr_en_appx` if `in_approx` is 1, otherwise `pwr_en_prec`.
- R3: When `in_valid` is low, both gate enables are low. On the next cycle `out_valid` and `out_exception` are low and `out_result` keeps its previous value.
- R4: One operation is accepted every cycle. Back-to-back operations with differing precision each produce their result exactly one cycle later, with no bubble.
- R5: An approximate result equals the exact result with bits [3:0] XORed with bits [3:0] of the LFSR value held in the cycle the operation is accepted. Bits above 3 are exact.
- R6: The LFSR resets to 16'hACE1. Its step shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. When `seed_load` is high, the next LFSR value is `seed_value`, and this takes priority over a step. An approximate operation in the same cycle still uses the value held before the load.
- R7: A precise add or subtract with signed overflow, or a precise opcode 7, sets `out_exception` together with its result.
- R8: An approximate operation never sets `out_exception`, including on overflow and on opcode 7.
- R9: Precise operations and idle cycles do not advance the LFSR. This shows in the noise of the next approximate result.
- R10: During and just after reset, `out_valid`, `out_exception` and `out_result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Load `seed_value` into the noise LFSR |
| seed_value | input | 16 | New LFSR value |
| in_valid | input | 1 | Operation offered this cycle |
| in_approx | input | 1 | 1 = approximate copy, 0 = precise copy |
| in_op | input | 3 | Opcode (see R1) |
| in_a | input | W (16) | Operand A |
| in_b | input | W (16) | Operand B |
| out_valid | output | 1 | Result valid |
| out_result | output | W (16) | Registered result |
| out_exception | output | 1 | Exception for the result on `out_result` |
| pwr_en_prec | output | 1 | Power-gate enable of the exact copy |
| pwr_en_appx | output | 1 | Power-gate enable of the shadow copy |

## Verification
The bench alternates the precision tag on every cycle. A design that inserted a switch penalty, or that registered the tag one cycle late, would then pair a result with the wrong copy. The bench drives signed overflow and opcode 7 under both tags: a design that let the shadow copy raise exceptions, or that dropped precise overflow detection, fails the exception compare. It runs long precise bursts between approximate operations and loads a seed in the same cycle as an approximate operation. A noise generator that stepped on every cycle, or that let the load win over the current value, would then corrupt the low bits differently from the behavioural model.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XNOR = 3'd4,
        OP_SRL  = 3'd5,
        OP_SLE  = 3'd6,
        OP_BAD  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREC = 2'd1,
        ST_APPX = 2'd2
    } unit_st_e;
endpackage

// File: rtl/alu_core.sv
module alu_core #(
    parameter int W = 16
) (
    input  alu_pkg::alu_op_e op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     y
);
    import alu_pkg::*;
    localparam int SHW = $clog2(W);

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XNOR: y = ~(a ^ b);
            OP_SRL:  y = a >> b[SHW-1:0];
            OP_SLE:  y = {{(W-1){1'b0}}, (a <= b)};
            OP_BAD:  y = '0;
        endcase
    end
endmodule

// File: rtl/exc_detect.sv
module exc_detect #(
    parameter int W = 16
) (
    input  alu_pkg::alu_op_e op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic             exc
);
    import alu_pkg::*;
    logic [W-1:0] sum, dif;

    always_comb begin
        sum = a + b;
        dif = a - b;
        unique case (op)
            OP_ADD:  exc = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            OP_SUB:  exc = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
            OP_BAD:  exc = 1'b1;
            default: exc = 1'b0;
        endcase
    end
endmodule

// File: rtl/err_lfsr.sv
module err_lfsr #(
    parameter logic [15:0] SEED_RST = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] seed,
    input  logic        step,
    output logic [15:0] state
);
    logic fb;
    assign fb = state[15] ^ state[13] ^ state[12] ^ state[10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= SEED_RST;
        else if (load) state <= seed;
        else if (step) state <= {state[14:0], fb};
    end
endmodule

// File: rtl/approx_unit.sv
module approx_unit #(
    parameter int W          = 16,
    parameter int NOISE_BITS = 4
) (
    input  alu_pkg::alu_op_e      op,
    input  logic [W-1:0]          a,
    input  logic [W-1:0]          b,
    input  logic [NOISE_BITS-1:0] noise,
    output logic [W-1:0]          y
);
    logic [W-1:0] exact;

    alu_core #(.W(W)) u_core (.op(op), .a(a), .b(b), .y(exact));

    generate
        if (NOISE_BITS < W) begin : g_part
            assign y = exact ^ {{(W-NOISE_BITS){1'b0}}, noise};
        end else begin : g_full
            assign y = exact ^ noise[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/dual_precision_alu.sv
module dual_precision_alu #(
    parameter int          W          = 16,
    parameter int          NOISE_BITS = 4,
    parameter logic [15:0] SEED_RST   = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed_load,
    input  logic [15:0]  seed_value,
    input  logic         in_valid,
    input  logic         in_approx,
    input  logic [2:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_exception,
    output logic         pwr_en_prec,
    output logic         pwr_en_appx
);
    import alu_pkg::*;

    unit_st_e     st_q, st_d;
    logic [15:0]  lfsr_q;
    alu_op_e      op_p, op_a;
    logic [W-1:0] a_p, b_p, a_a, b_a, y_p, y_a;
    logic         exc_p;

    assign pwr_en_prec = in_valid && !in_approx;
    assign pwr_en_appx = in_valid && in_approx;

    // operand isolation: the gated copy sees constant inputs
    assign op_p = pwr_en_prec ? alu_op_e'(in_op) : OP_AND;
    assign a_p  = pwr_en_prec ? in_a : '0;
    assign b_p  = pwr_en_prec ? in_b : '0;
    assign op_a = pwr_en_appx ? alu_op_e'(in_op) : OP_AND;
    assign a_a  = pwr_en_appx ? in_a : '0;
    assign b_a  = pwr_en_appx ? in_b : '0;

    alu_core #(.W(W)) u_prec (.op(op_p), .a(a_p), .b(b_p), .y(y_p));

    exc_detect #(.W(W)) u_exc (.op(op_p), .a(a_p), .b(b_p), .exc(exc_p));

    approx_unit #(.W(W), .NOISE_BITS(NOISE_BITS)) u_appx (
        .op(op_a), .a(a_a), .b(b_a),
        .noise(lfsr_q[NOISE_BITS-1:0]), .y(y_a)
    );

    err_lfsr #(.SEED_RST(SEED_RST)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed_value),
        .step(pwr_en_appx), .state(lfsr_q)
    );

    always_comb begin
        if (!in_valid)     st_d = ST_IDLE;
        else if (in_approx) st_d = ST_APPX;
        else               st_d = ST_PREC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result    <= '0;
            out_exception <= 1'b0;
        end else begin
            unique case (st_d)
                ST_IDLE: out_exception <= 1'b0;
                ST_PREC: begin
                    out_result    <= y_p;
                    out_exception <= exc_p;
                end
                ST_APPX: begin
                    out_result    <= y_a;
                    out_exception <= 1'b0;
                end
                default: out_exception <= 1'b0;
            endcase
        end
    end

    assign out_valid = (st_q != ST_IDLE);
endmodule

// File: rtl/dual_alu_chk.sv
module dual_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_approx,
    input logic        seed_load,
    input logic        pwr_en_prec,
    input logic        pwr_en_appx,
    input logic        out_valid,
    input logic        out_exception,
    input logic [15:0] lfsr_q
);
    AST_SINGLE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot({pwr_en_prec, pwr_en_appx}) && (pwr_en_appx == in_approx)); // R2
    AST_IDLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !pwr_en_prec && !pwr_en_appx); // R3
    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_exception); // R3
    AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R4
    AST_APPX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_approx) |=> !out_exception); // R8
    AST_NOISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_approx) && !seed_load |=> $stable(lfsr_q)); // R9
endmodule

bind dual_precision_alu dual_alu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_approx(in_approx),
    .seed_load(seed_load), .pwr_en_prec(pwr_en_prec), .pwr_en_appx(pwr_en_appx),
    .out_valid(out_valid), .out_exception(out_exception), .lfsr_q(lfsr_q)
);

// File: tb/sim_dual_precision_alu.sv
module sim_dual_precision_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_value = '0;
    logic        in_valid = 1'b0;
    logic        in_approx = 1'b0;
    logic [2:0]  in_op = '0;
    logic [15:0] in_a = '0;
    logic [15:0] in_b = '0;
    logic        out_valid, out_exception, pwr_en_prec, pwr_en_appx;
    logic [15:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_lfsr = 16'hACE1;
    logic [15:0] m_res = '0;
    logic        m_val = 1'b0;
    logic        m_exc = 1'b0;

    always #10 clk = ~clk;

    dual_precision_alu u0 (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
        .in_valid(in_valid), .in_approx(in_approx), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
        .out_exception(out_exception), .pwr_en_prec(pwr_en_prec), .pwr_en_appx(pwr_en_appx)
    );

    function automatic logic [15:0] ref_val(input logic [2:0] op, input logic [15:0] a, b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return ~(a ^ b);
            3'd5: return a >> b[3:0];
            3'd6: return (a <= b) ? 16'd1 : 16'd0;
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic ref_exc(input logic [2:0] op, input logic [15:0] a, b);
        int sa, sb, r;
        sa = $signed(a);
        sb = $signed(b);
        if (op == 3'd0) begin r = sa + sb; return (r > 32767) || (r < -32768); end
        if (op == 3'd1) begin r = sa - sb; return (r > 32767) || (r < -32768); end
        return op == 3'd7;
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic cyc(input string tag, input logic v, ap, input logic [2:0] op,
                       input logic [15:0] a, b, input logic ld = 1'b0,
                       input logic [15:0] sd = 16'h0);
        in_valid = v; in_approx = ap; in_op = op; in_a = a; in_b = b;
        seed_load = ld; seed_value = sd;
        #1;
        if (v) begin
            chk("R2 prec gate", {31'd0, pwr_en_prec}, {31'd0, !ap});
            chk("R2 appx gate", {31'd0, pwr_en_appx}, {31'd0, ap});
        end else begin
            chk("R3 gates off", {30'd0, pwr_en_prec, pwr_en_appx}, 32'd0);
        end
        @(posedge clk);
        m_val = v;
        if (v && ap) begin
            m_res = ref_val(op, a, b) ^ {12'd0, m_lfsr[3:0]};
            m_exc = 1'b0;
        end else if (v) begin
            m_res = ref_val(op, a, b);
            m_exc = ref_exc(op, a, b);
        end else begin
            m_exc = 1'b0;
        end
        if (ld) m_lfsr = sd;
        else if (v && ap) m_lfsr = lfsr_next(m_lfsr);
        @(negedge clk);
        chk(v ? "R4 valid" : "R3 valid", {31'd0, out_valid}, {31'd0, m_val});
        chk(ap && v ? "R8 exception" : (v ? "R7 exception" : "R3 exception"),
            {31'd0, out_exception}, {31'd0, m_exc});
        chk(tag, {16'd0, out_result}, {16'd0, m_res});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R10 reset state
        chk("R10 valid", {31'd0, out_valid}, 32'd0);
        chk("R10 exception", {31'd0, out_exception}, 32'd0);
        chk("R10 result", {16'd0, out_result}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 result after release", {16'd0, out_result}, 32'd0);

        // R1 each opcode, precise
        cyc("R1 add", 1, 0, 3'd0, 16'h1234, 16'h0FFF);
        cyc("R1 sub", 1, 0, 3'd1, 16'h0005, 16'h0009);
        cyc("R1 and", 1, 0, 3'd2, 16'hF0F0, 16'h3C3C);
        cyc("R1 or",  1, 0, 3'd3, 16'hF000, 16'h000F);
        cyc("R1 xnor",1, 0, 3'd4, 16'hAAAA, 16'h5555);
        cyc("R1 srl", 1, 0, 3'd5, 16'h8000, 16'h001F);
        cyc("R1 sle eq", 1, 0, 3'd6, 16'h7777, 16'h7777);
        cyc("R1 sle gt", 1, 0, 3'd6, 16'hFFFF, 16'h0001);
        // R7 precise exceptions
        cyc("R7 add ovf", 1, 0, 3'd0, 16'h7FFF, 16'h0001);
        cyc("R7 sub ovf", 1, 0, 3'd1, 16'h8000, 16'h0001);
        cyc("R7 bad op",  1, 0, 3'd7, 16'h1111, 16'h2222);
        // R8 approximate never raises
        cyc("R8 add ovf appx", 1, 1, 3'd0, 16'h7FFF, 16'h0001);
        cyc("R8 bad op appx",  1, 1, 3'd7, 16'h1111, 16'h2222);
        // R3 idle holds result
        cyc("R3 hold", 0, 0, 3'd0, 16'hDEAD, 16'hBEEF);
        cyc("R3 hold", 0, 1, 3'd0, 16'hDEAD, 16'hBEEF);
        // R4 alternating precision, no bubbles; R5 noise in low bits
        for (int i = 0; i < 12; i++)
            cyc(i % 2 ? "R5 alt appx" : "R4 alt prec", 1, i % 2, 3'(i % 7),
                16'(16'h1357 * (i + 1)), 16'(16'h0246 + i));
        // R6 seed load, then load in same cycle as an approximate op
        cyc("R6 load", 0, 0, 3'd0, 0, 0, 1'b1, 16'h000F);
        cyc("R6 first noise", 1, 1, 3'd2, 16'h0000, 16'h0000);
        cyc("R6 load with op", 1, 1, 3'd3, 16'h0100, 16'h0000, 1'b1, 16'h1234);
        cyc("R6 after load", 1, 1, 3'd3, 16'h0100, 16'h0000);
        // R9 precise burst between approximate ops must not step noise
        cyc("R9 before", 1, 1, 3'd0, 16'h0010, 16'h0020);
        for (int i = 0; i < 9; i++)
            cyc("R9 precise burst", 1, 0, 3'd0, 16'(i), 16'h0001);
        cyc("R9 idle", 0, 0, 3'd0, 0, 0);
        cyc("R9 after", 1, 1, 3'd0, 16'h0010, 16'h0020);
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic v, ap;
            v  = ($urandom % 5) != 0;
            ap = $urandom % 2;
            cyc(ap ? "R5 rand appx" : "R1 rand prec", v, ap, 3'($urandom),
                16'($urandom), 16'($urandom), ($urandom % 23) == 0, 16'($urandom | 1));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule